// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block holds the software-visible state of a general-purpose I/O port built from several banks of eight lines each. Every bank owns two 8-bit registers on a 32-bit register bus. The value register supplies the level driven onto output lines. The mode register chooses, line by line, whether the pad is driven or only observed. Software changes single lines by reading a register, editing bits under a mask and writing the result back. Every register must therefore return exactly what was last written, apart from value bits of lines that are configured as inputs.

Bank `b` sits at base address `(b+1)*8`. When that base lands at or above 0x90, the block moves it up by 0x10, so the window 0x90 to 0x9F stays free for interrupt control kept elsewhere. Inputs cross into the clock domain through two flip-flop stages before software can read them. Read data appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every mode bit is 1 (input), every value bit is 0, `pin_oe` is all zero, `pin_out` is all zero and `bus_rdata` is zero.
- R2: Line n belongs to bank n/8 and uses bit n%8 of that bank's registers, so it drives `pin_out[n]`, `pin_oe[n]` and is read from `pin_in[n]`.
- R3: The value register of bank b is at offset 0 from its base and the mode register at offset 4. The base is (b+1)*8, plus 0x10 when (b+1)*8 is 0x90 or more. No register answers between 0x90 and 0x9F.
- R4: The mode register reads back the low 8 bits last written to it. Bits 31:8 of every read are zero.
- R5: Mode bit 1 makes a line an input with `pin_oe` low. Mode bit 0 sets `pin_oe` high and drives `pin_out` from the value bit.
- R6: For a line in output mode, the value register reads back the bit last written, whatever the pad level on `pin_in`.
- R7: For a line in input mode, the value register reads the pad level after two synchronizing flops. A pad change driven before clock edge k is returned by a read sampled at edge k+2 and not by reads sampled at edges k or k+1.
- R8: Writing the value register while a line is an input updates `pin_out` but leaves `pin_oe` low. When the mode bit is later cleared, `pin_oe` rises with `pin_out` already at the new value, never at a stale one.
- R9: Any address that matches no register (inside the reserved window, below bank 0, beyond the last bank or not on a register boundary) reads as zero, and a write to it changes no register or pin.
- R10: `bus_rdata` is loaded on the clock edge that samples `bus_rd_en` high and keeps its value on edges where `bus_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data; only the low 8 bits are stored |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8*NUM_BANKS | Pad levels sampled from the lines |
| pin_out | output | 8*NUM_BANKS | Level driven onto each line |
| pin_oe | output | 8*NUM_BANKS | Output enable for each line, 1 = drive |

## Verification
The bench targets the address map at its seams: bank 16 just below the reserved window, bank 17 whose base would fall at 0x90 without the jump, the window itself, the last bank, addresses past it, and misaligned addresses. A decoder that skipped the jump would alias bank 17 onto 0x90 and fail the read-back there. A decoder that matched loosely would let stray writes change the pins. Synchronizer depth is measured with back-to-back reads at the two edges after a pad change, so a missing or extra flop shows as an early or late value. A value write made before the mode bit is cleared is checked at the pins, which catches a design that enables the driver before the value has landed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned LINES_PER_BANK = 8;
  localparam int unsigned REG_W          = 32;
  localparam int unsigned VAL_OFS        = 0;
  localparam int unsigned MODE_OFS       = 4;
  localparam int unsigned BANK_STRIDE    = 8;
  localparam int unsigned HOLE_START     = 32'h90;
  localparam int unsigned HOLE_SPAN      = 32'h10;

  // Base byte address of a bank; banks that would land in the reserved
  // interrupt window are pushed past it.
  function automatic int unsigned bank_base(input int unsigned bank);
    int unsigned a;
    a = (bank + 1) * BANK_STRIDE;
    if (a >= HOLE_START) a = a + HOLE_SPAN;
    return a;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 20,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] val_sel,
  output logic [NUM_BANKS-1:0] mode_sel,
  output logic                 hit
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    localparam int unsigned BASE = bank_base(b);
    assign val_sel[b]  = (addr == ADDR_W'(BASE + VAL_OFS));
    assign mode_sel[b] = (addr == ADDR_W'(BASE + MODE_OFS));
  end

  assign hit = (|val_sel) | (|mode_sel);
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         val_we,
  input  logic         mode_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_sync,
  output logic [W-1:0] val_view,
  output logic [W-1:0] mode_view,
  output logic [W-1:0] drive,
  output logic [W-1:0] drive_en
);
  logic [W-1:0] val_q;
  logic [W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      mode_q <= '1;
    end else begin
      if (val_we)  val_q  <= wdata;
      if (mode_we) mode_q <= wdata;
    end
  end

  // Input lines show the pad, output lines show the stored value.
  assign val_view  = (mode_q & pad_sync) | (~mode_q & val_q);
  assign mode_view = mode_q;
  assign drive     = val_q;
  assign drive_en  = ~mode_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 20,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned LINES    = NUM_BANKS * LINES_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe
);
  localparam int unsigned LPB = LINES_PER_BANK;

  logic [NUM_BANKS-1:0]          val_sel;
  logic [NUM_BANKS-1:0]          mode_sel;
  logic                          map_hit;
  logic [LINES-1:0]              pad_sync;
  logic [NUM_BANKS-1:0][LPB-1:0] val_view;
  logic [NUM_BANKS-1:0][LPB-1:0] mode_view;
  logic [REG_W-1:0]              rd_mux;
  logic                          wdata_unused;

  assign wdata_unused = ^bus_wdata[REG_W-1:LPB];

  gpio_in_sync #(.WIDTH(LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pad_sync)
  );

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .val_sel  (val_sel),
    .mode_sel (mode_sel),
    .hit      (map_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_port_bank #(.W(LPB)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .val_we    (bus_wr_en & val_sel[b]),
      .mode_we   (bus_wr_en & mode_sel[b]),
      .wdata     (bus_wdata[LPB-1:0]),
      .pad_sync  (pad_sync[b*LPB +: LPB]),
      .val_view  (val_view[b]),
      .mode_view (mode_view[b]),
      .drive     (pin_out[b*LPB +: LPB]),
      .drive_en  (pin_oe[b*LPB +: LPB])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (val_sel[b])  rd_mux = rd_mux | REG_W'(val_view[b]);
      if (mode_sel[b]) rd_mux = rd_mux | REG_W'(mode_view[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int unsigned LINES = 160
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr_en,
  input logic             bus_rd_en,
  input logic [31:0]      bus_rdata,
  input logic [LINES-1:0] pin_out,
  input logic [LINES-1:0] pin_oe,
  input logic             map_hit
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R4
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:8] == 24'h0);

  // R8
  oe_rise_no_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((pin_oe & ~$past(pin_oe)) & (pin_out ^ $past(pin_out))) == '0);

  // R9
  stray_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !map_hit) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R9
  stray_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !map_hit) |=> bus_rdata == 32'h0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(bus_rd_en)) |-> $stable(bus_rdata));

  // R5
  oe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(bus_wr_en)) |-> $stable(pin_oe));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.LINES(LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .map_hit   (map_hit)
);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  localparam int NB = 20;
  localparam int NL = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out;
  logic [NL-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  adr_q[$];

  always #10 clk = ~clk;

  gpio_bank_regs #(.NUM_BANKS(NB), .ADDR_W(8)) i_gpio_bank_regs (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe)
  );

  // Bench view of the address map, written independently.
  function automatic logic [7:0] base_of(input int b);
    int a;
    a = 8 * b + 8;
    return (a < 144) ? 8'(a) : 8'(a + 16);
  endfunction

  // Monitor: compare each read result one cycle after the strobe.
  always @(posedge clk) rd_seen <= bus_rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      logic [7:0] a;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = adr_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s read 0x%02h actual 0x%08h expected 0x%08h", t, a, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t); adr_q.push_back(a);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic chk(input string t, input logic [NL-1:0] act, input logic [NL-1:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", t, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] out_snap, oe_snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 rdata", {{(NL-32){1'b0}}, bus_rdata}, '0);
    rst_n = 1'b1;
    rd(base_of(0) + 8'd4, 32'h0000_00FF, "R1 mode");
    rd(base_of(0), 32'h0, "R1 value");

    // R8 value first, then mode
    wr(base_of(0), 32'h5A);
    chk("R8 pin_out before mode", {{(NL-8){1'b0}}, pin_out[7:0]}, NL'(8'h5A));
    chk("R8 pin_oe before mode", pin_oe, '0);
    wr(base_of(0) + 8'd4, 32'h0);
    chk("R5 pin_oe bank0", {{(NL-8){1'b0}}, pin_oe[7:0]}, NL'(8'hFF));
    chk("R8 pin_out after mode", {{(NL-8){1'b0}}, pin_out[7:0]}, NL'(8'h5A));
    rd(base_of(0), 32'h5A, "R6 output value");
    rd(base_of(0) + 8'd4, 32'h0, "R4 mode");

    // R6 output lines ignore the pad
    pin_in[7:0] = 8'hFF;
    repeat (3) @(negedge clk);
    rd(base_of(0), 32'h5A, "R6 pad ignored");

    // R7 mixed bank 2, R4 upper bits dropped
    pin_in[23:16] = 8'hAA;
    wr(base_of(2), 32'hC3);
    wr(base_of(2) + 8'd4, 32'hFFFF_FF0F);
    rd(base_of(2) + 8'd4, 32'h0F, "R4 low byte kept");
    rd(base_of(2), 32'hCA, "R7 mixed value");
    chk("R5 pin_oe bank2", {{(NL-8){1'b0}}, pin_oe[23:16]}, NL'(8'hF0));
    chk("R2 pin_out bank2", {{(NL-8){1'b0}}, pin_out[23:16]}, NL'(8'hC3));

    // R3 banks around the window
    rd(8'h88 + 8'd4, 32'hFF, "R3 bank16 mode");
    wr(8'hA0, 32'h3C);
    wr(8'hA4, 32'h00);
    rd(8'hA0, 32'h3C, "R3 bank17 value");
    chk("R2 pin_out bank17", {{(NL-8){1'b0}}, pin_out[143:136]}, NL'(8'h3C));
    chk("R2 pin_oe bank17", {{(NL-8){1'b0}}, pin_oe[143:136]}, NL'(8'hFF));
    wr(8'hB4, 32'h7E);
    rd(8'hB4, 32'h7E, "R3 last bank mode");
    wr(8'hB4, 32'hFF);

    // R9 stray addresses
    out_snap = pin_out;
    oe_snap  = pin_oe;
    wr(8'h90, 32'hFF); wr(8'h94, 32'hFF); wr(8'h98, 32'hFF); wr(8'h9C, 32'hFF);
    wr(8'hB8, 32'hFF); wr(8'h00, 32'hFF); wr(8'h04, 32'hFF); wr(8'h09, 32'hFF);
    chk("R9 pin_out unchanged", pin_out, out_snap);
    chk("R9 pin_oe unchanged", pin_oe, oe_snap);
    rd(8'h90, 32'h0, "R9 window read");
    rd(8'h9C, 32'h0, "R9 window read");
    rd(8'hB8, 32'h0, "R9 beyond last");
    rd(8'h0A, 32'h0, "R9 misaligned");
    rd(8'hA0, 32'h3C, "R3 bank17 not aliased");

    // R7 synchronizer depth on bank 1 (input lines)
    @(negedge clk);
    pin_in[15:8] = 8'h81;
    bus_addr = base_of(1); bus_rd_en = 1'b1;
    exp_q.push_back(32'h0); tag_q.push_back("R7 edge k"); adr_q.push_back(base_of(1));
    @(negedge clk);
    exp_q.push_back(32'h0); tag_q.push_back("R7 edge k+1"); adr_q.push_back(base_of(1));
    @(negedge clk);
    exp_q.push_back(32'h81); tag_q.push_back("R7 edge k+2"); adr_q.push_back(base_of(1));
    @(negedge clk);
    bus_rd_en = 1'b0;

    // R10 read data holds
    repeat (4) @(negedge clk);
    chk("R10 rdata held", {{(NL-32){1'b0}}, bus_rdata}, NL'(32'h81));

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule